// File: doc/BRIEF.md
# CAN Frame Receiver with Interframe Monitor

This block takes a CAN bit stream that a bit-timing stage has already sampled. Each bit arrives on a one-cycle strobe, and a flag marks stuff bits. The receiver follows the frame field by field. It detects start-of-frame and reads the base identifier. The identifier-extension position then selects one of two layouts: the standard layout, or the extended layout with an 18-bit identifier extension. After that it reads the control field and the data bytes, and it accumulates a 15-bit CRC. The CRC it computes is compared with the CRC carried in the frame.

If the CRC matches, the block raises an acknowledge request for the ACK slot. It then checks that the delimiters and the end-of-frame field are recessive. When the last end-of-frame bit arrives, it pulses a frame-valid strobe and presents the identifier, the format, the RTR bit, the DLC and up to eight data bytes.

After each frame the block counts the intermission slots. A dominant bit in the first or second slot raises an overload indication. A dominant bit in the third slot starts a new frame. After three recessive slots the bus is idle, and the next dominant bit starts a new frame. Bit timing, error counters and error-frame generation are handled elsewhere.

Top module: `can_frame_rx`

## Requirements
- R1: While the bus is idle, a dominant bit (bit_val=0) pulses sof_det for one cycle, drops bus_idle and starts a frame. A recessive bit leaves the block idle with no pulse.
- R2: The bit after the 11 base identifier bits and the following bit together select the layout. If the identifier-extension bit is dominant, the frame is standard: frm_ext=0, the base identifier goes in frm_id[28:18], frm_id[17:0]=0, and the bit before the extension bit is the RTR. If it is recessive, the frame is extended: 18 more identifier bits fill frm_id[17:0] MSB first, and the next bit is the RTR.
- R3: Reserved control bits are accepted at either level and have no effect on the result.
- R4: The 4-bit DLC is received MSB first. A DLC of 8 to 15 means eight data bytes, and an RTR frame carries no data. The first data byte lands in frm_data[7:0], each byte is sent MSB first, and bytes that were not received read as zero.
- R5: The CRC uses polynomial 0x4599 with a zero start value. It covers SOF through the data field and is compared with the 15 received CRC bits. On a mismatch, crc_err pulses at the CRC delimiter, no acknowledge is requested and frm_vld stays low.
- R6: When the CRC matches, ack_drive goes high after the CRC delimiter bit and drops after the ACK slot bit.
- R7: A dominant bit at the CRC delimiter, the ACK delimiter or any end-of-frame bit pulses form_err, drops the frame without frm_vld, and returns the block to idle.
- R8: After the seventh recessive end-of-frame bit of a frame with a good CRC, frm_vld pulses for one cycle with the frame fields on the outputs.
- R9: A dominant bit in intermission slot 1 or 2 pulses ovld_det. The block then waits for eight consecutive recessive bits before intermission starts again. A dominant bit in slot 3 pulses sof_det and starts a frame.
- R10: Strobes flagged as stuff bits change neither the parser nor the CRC.
- R11: After three recessive intermission bits, bus_idle is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | One-cycle strobe: a sampled bit is present |
| bit_val | input | 1 | Bus level of the bit, 0 dominant, 1 recessive |
| bit_stuff | input | 1 | The strobed bit is a stuff bit |
| frm_vld | output | 1 | One-cycle pulse: an error-free frame has completed |
| frm_id | output | 29 | Identifier, base in [28:18], extension in [17:0] |
| frm_ext | output | 1 | Extended layout |
| frm_rtr | output | 1 | Remote request |
| frm_dlc | output | 4 | Raw DLC as received |
| frm_data | output | 64 | Data bytes, first byte in [7:0] |
| ack_drive | output | 1 | Request to drive dominant in the ACK slot |
| sof_det | output | 1 | Pulse: start-of-frame taken |
| ovld_det | output | 1 | Pulse: overload condition in intermission |
| form_err | output | 1 | Pulse: dominant bit in a fixed recessive field |
| crc_err | output | 1 | Pulse: CRC mismatch |
| bus_idle | output | 1 | Bus idle after intermission |

## Verification
The bench uses the default widths: a 15-bit CRC, a 29-bit identifier and an 8-byte payload. With these it can send extended frames with a full 64-bit payload and a DLC above eight, which exercises the cap at eight bytes and the highest data bit positions. The bench builds its frames from a local bit list and inserts true stuff bits after every run of five equal bits. This puts the stuff-bit skipping under long runs of equal bits in identifier and data. The bench also drives the three intermission slots one at a time, so both the overload path and the slot-3 start-of-frame path are covered.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    localparam int CRC_W      = 15;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
    localparam int BASE_ID_W  = 11;
    localparam int EXT_ID_W   = 18;
    localparam int ID_W       = BASE_ID_W + EXT_ID_W;
    localparam int MAX_BYTES  = 8;
    localparam int DATA_W     = MAX_BYTES * 8;
    localparam int DLC_W      = 4;
    localparam int EOF_LEN    = 7;
    localparam int INTER_LEN  = 3;
    localparam int OVLD_DELIM = 8;
    localparam int CNT_W      = 7;

    typedef enum logic [4:0] {
        ST_IDLE, ST_BASE, ST_SRR, ST_IDE, ST_XID, ST_XRTR, ST_R1, ST_R0,
        ST_DLC, ST_DATA, ST_CRC, ST_CDEL, ST_ACK, ST_ADEL, ST_EOF,
        ST_INTER, ST_OVLD
    } rx_state_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } can_frame_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        logic [CRC_W-1:0] n;
        fb = c[CRC_W-1] ^ b;
        n  = {c[CRC_W-2:0], 1'b0};
        return fb ? (n ^ CRC_POLY) : n;
    endfunction

    function automatic logic [DLC_W-1:0] payload_bytes(input logic [DLC_W-1:0] dlc, input logic rtr);
        if (rtr) return '0;
        if (dlc >= DLC_W'(MAX_BYTES)) return DLC_W'(MAX_BYTES);
        return dlc;
    endfunction

endpackage

// File: rtl/can_rx_crc.sv
module can_rx_crc
    import can_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst)
            crc <= '0;
        else if (en)
            crc <= crc_step(clr ? '0 : crc, din);
    end

    // R10: without an enable (stuff bits never enable) the remainder holds
    a_r10_crc_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(crc));

endmodule

// File: rtl/can_rx_parser.sv
module can_rx_parser
    import can_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             bit_stuff,
    input  logic [CRC_W-1:0] crc_calc,
    output logic             crc_clr,
    output logic             crc_en,
    output can_frame_t       frm,
    output logic             frm_vld,
    output logic             ack_drive,
    output logic             sof_det,
    output logic             ovld_det,
    output logic             form_err,
    output logic             crc_err,
    output logic             bus_idle
);

    rx_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic             take, dom, srr_rtr, crc_good;
    logic [CRC_W-1:0] rx_crc;
    logic [DLC_W-1:0] nbytes, dlc_next, nb_next;

    assign take     = bit_vld & ~bit_stuff;
    assign dom      = ~bit_val;
    assign dlc_next = {frm.dlc[DLC_W-2:0], bit_val};
    assign nb_next  = payload_bytes(dlc_next, frm.rtr);
    assign bus_idle = (st == ST_IDLE);

    assign crc_clr = take & dom & ((st == ST_IDLE) |
                     ((st == ST_INTER) & (cnt == CNT_W'(INTER_LEN-1))));
    assign crc_en  = crc_clr | (take & (st inside {ST_BASE, ST_SRR, ST_IDE, ST_XID,
                     ST_XRTR, ST_R1, ST_R0, ST_DLC, ST_DATA}));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; cnt <= '0; frm <= '0; srr_rtr <= 1'b0;
            rx_crc <= '0; crc_good <= 1'b0; nbytes <= '0; ack_drive <= 1'b0;
            frm_vld <= 1'b0; sof_det <= 1'b0; ovld_det <= 1'b0;
            form_err <= 1'b0; crc_err <= 1'b0;
        end else begin
            frm_vld <= 1'b0; sof_det <= 1'b0; ovld_det <= 1'b0;
            form_err <= 1'b0; crc_err <= 1'b0;
            if (take) begin
                cnt <= cnt + 1'b1;
                case (st)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (dom) begin
                            sof_det <= 1'b1; st <= ST_BASE; frm <= '0;
                        end
                    end
                    ST_BASE: begin
                        frm.id[ID_W-1:EXT_ID_W] <= {frm.id[ID_W-2:EXT_ID_W], bit_val};
                        if (cnt == CNT_W'(BASE_ID_W-1)) st <= ST_SRR;
                    end
                    ST_SRR: begin
                        srr_rtr <= bit_val; st <= ST_IDE;
                    end
                    ST_IDE: begin
                        frm.ext <= bit_val; cnt <= '0;
                        if (bit_val) st <= ST_XID;
                        else begin frm.rtr <= srr_rtr; st <= ST_R0; end
                    end
                    ST_XID: begin
                        frm.id[EXT_ID_W-1:0] <= {frm.id[EXT_ID_W-2:0], bit_val};
                        if (cnt == CNT_W'(EXT_ID_W-1)) st <= ST_XRTR;
                    end
                    ST_XRTR: begin frm.rtr <= bit_val; st <= ST_R1; end
                    ST_R1:   st <= ST_R0;
                    ST_R0:   begin st <= ST_DLC; cnt <= '0; end
                    ST_DLC: begin
                        frm.dlc <= dlc_next;
                        if (cnt == CNT_W'(DLC_W-1)) begin
                            nbytes <= nb_next; cnt <= '0;
                            st <= (nb_next == '0) ? ST_CRC : ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        frm.data[{cnt[5:3], ~cnt[2:0]}] <= bit_val;
                        if (cnt == ({nbytes, 3'b000} - 7'd1)) begin
                            cnt <= '0; st <= ST_CRC;
                        end
                    end
                    ST_CRC: begin
                        rx_crc <= {rx_crc[CRC_W-2:0], bit_val};
                        if (cnt == CNT_W'(CRC_W-1)) st <= ST_CDEL;
                    end
                    ST_CDEL: begin
                        if (dom) begin
                            form_err <= 1'b1; st <= ST_IDLE;
                        end else begin
                            crc_good  <= (rx_crc == crc_calc);
                            ack_drive <= (rx_crc == crc_calc);
                            crc_err   <= (rx_crc != crc_calc);
                            st <= ST_ACK;
                        end
                    end
                    ST_ACK: begin ack_drive <= 1'b0; st <= ST_ADEL; end
                    ST_ADEL: begin
                        cnt <= '0;
                        if (dom) begin form_err <= 1'b1; st <= ST_IDLE; end
                        else st <= ST_EOF;
                    end
                    ST_EOF: begin
                        if (dom) begin
                            form_err <= 1'b1; st <= ST_IDLE;
                        end else if (cnt == CNT_W'(EOF_LEN-1)) begin
                            frm_vld <= crc_good; st <= ST_INTER; cnt <= '0;
                        end
                    end
                    ST_INTER: begin
                        if (dom) begin
                            cnt <= '0;
                            if (cnt == CNT_W'(INTER_LEN-1)) begin
                                sof_det <= 1'b1; st <= ST_BASE; frm <= '0;
                            end else begin
                                ovld_det <= 1'b1; st <= ST_OVLD;
                            end
                        end else if (cnt == CNT_W'(INTER_LEN-1)) begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_OVLD: begin
                        if (dom) cnt <= '0;
                        else if (cnt == CNT_W'(OVLD_DELIM-1)) begin
                            st <= ST_INTER; cnt <= '0;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: a stuff-marked strobe leaves the parser where it was
    a_r10_stuff_ignored: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && bit_stuff) |=> ($stable(st) && $stable(cnt)));
    // R1, R9: start-of-frame only from idle or intermission
    a_r1_sof_origin: assert property (@(posedge clk) disable iff (rst)
        sof_det |-> ($past(st) == ST_IDLE || $past(st) == ST_INTER));
    // R6: acknowledge request only rises out of the CRC delimiter
    a_r6_ack_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_drive) |-> $past(st) == ST_CDEL);
    // R5: a CRC mismatch never comes with an acknowledge request
    a_r5_no_ack_on_crc_err: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> !ack_drive);
    // R8: event pulses are mutually exclusive
    a_r8_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frm_vld, sof_det, ovld_det, form_err, crc_err}));

endmodule

// File: rtl/can_frame_rx.sv
module can_frame_rx
    import can_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              bit_stuff,
    output logic              frm_vld,
    output logic [ID_W-1:0]   frm_id,
    output logic              frm_ext,
    output logic              frm_rtr,
    output logic [DLC_W-1:0]  frm_dlc,
    output logic [DATA_W-1:0] frm_data,
    output logic              ack_drive,
    output logic              sof_det,
    output logic              ovld_det,
    output logic              form_err,
    output logic              crc_err,
    output logic              bus_idle
);

    logic             crc_clr, crc_en;
    logic [CRC_W-1:0] crc_calc;
    can_frame_t       frm;

    can_rx_crc u_crc (
        .clk (clk), .rst (rst), .clr (crc_clr), .en (crc_en),
        .din (bit_val), .crc (crc_calc)
    );

    can_rx_parser u_parser (
        .clk (clk), .rst (rst), .bit_vld (bit_vld), .bit_val (bit_val),
        .bit_stuff (bit_stuff), .crc_calc (crc_calc), .crc_clr (crc_clr),
        .crc_en (crc_en), .frm (frm), .frm_vld (frm_vld),
        .ack_drive (ack_drive), .sof_det (sof_det), .ovld_det (ovld_det),
        .form_err (form_err), .crc_err (crc_err), .bus_idle (bus_idle)
    );

    assign frm_id   = frm.id;
    assign frm_ext  = frm.ext;
    assign frm_rtr  = frm.rtr;
    assign frm_dlc  = frm.dlc;
    assign frm_data = frm.data;

endmodule

// File: tb/can_frame_rx_bench.sv
`timescale 1ns/1ps
module can_frame_rx_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0, bit_val = 1'b1, bit_stuff = 1'b0;
    logic frm_vld, frm_ext, frm_rtr, ack_drive, sof_det, ovld_det;
    logic form_err, crc_err, bus_idle;
    logic [28:0] frm_id;
    logic [3:0]  frm_dlc;
    logic [63:0] frm_data;

    int n_chk = 0, n_err = 0;
    logic fb [200];
    int fl;

    always #4 clk = ~clk;

    can_frame_rx u_can_frame_rx (
        .clk (clk), .rst (rst), .bit_vld (bit_vld), .bit_val (bit_val),
        .bit_stuff (bit_stuff), .frm_vld (frm_vld), .frm_id (frm_id),
        .frm_ext (frm_ext), .frm_rtr (frm_rtr), .frm_dlc (frm_dlc),
        .frm_data (frm_data), .ack_drive (ack_drive), .sof_det (sof_det),
        .ovld_det (ovld_det), .form_err (form_err), .crc_err (crc_err),
        .bus_idle (bus_idle)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic v, input logic s);
        @(negedge clk);
        bit_vld = 1'b1; bit_val = v; bit_stuff = s;
        @(negedge clk);
        bit_vld = 1'b0; bit_val = 1'b1; bit_stuff = 1'b0;
    endtask

    task automatic push(input logic v);
        fb[fl] = v; fl++;
    endtask

    task automatic build(input logic ext, input logic [28:0] id, input logic rtr,
                         input logic [3:0] dlc, input logic [63:0] data, input logic rsv);
        logic [14:0] c;
        int nb;
        fl = 0;
        push(1'b0);
        for (int i = 0; i < 11; i++) push(id[28-i]);
        if (ext) begin
            push(1'b1); push(1'b1);
            for (int i = 0; i < 18; i++) push(id[17-i]);
            push(rtr); push(rsv); push(rsv);
        end else begin
            push(rtr); push(1'b0); push(rsv);
        end
        for (int i = 0; i < 4; i++) push(dlc[3-i]);
        nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
        for (int b = 0; b < nb; b++)
            for (int k = 0; k < 8; k++) push(data[b*8+7-k]);
        c = '0;
        for (int i = 0; i < fl; i++) begin
            logic f;
            f = c[14] ^ fb[i];
            c = {c[13:0], 1'b0};
            if (f) c = c ^ 15'h4599;
        end
        for (int i = 0; i < 15; i++) push(c[14-i]);
    endtask

    // sends the body with a flagged stuff bit after every five equal bits
    task automatic send_body();
        int run;
        logic last;
        run = 0; last = 1'b1;
        for (int i = 0; i < fl; i++) begin
            send_bit(fb[i], 1'b0);
            if (i == 0) chk("R1 sof pulse on dominant from idle/intermission", 64'(sof_det), 64'd1);
            run  = (i > 0 && fb[i] == last) ? run + 1 : 1;
            last = fb[i];
            if (run == 5 && i < fl - 1) begin
                send_bit(~fb[i], 1'b1);
                last = ~fb[i]; run = 1;
            end
        end
    endtask

    task automatic send_tail(input logic good);
        send_bit(1'b1, 1'b0);
        chk("R6 ack_drive after CRC delimiter", 64'(ack_drive), 64'(good));
        chk("R5 crc_err at CRC delimiter", 64'(crc_err), 64'(!good));
        send_bit(1'b0, 1'b0);
        chk("R6 ack_drive released after ACK slot", 64'(ack_drive), 64'd0);
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
    endtask

    task automatic rx_frame(input string tag, input logic ext, input logic [28:0] id,
                            input logic rtr, input logic [3:0] dlc,
                            input logic [63:0] data, input logic rsv);
        logic [63:0] mask;
        int nb;
        nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
        mask = (nb == 8) ? '1 : ((64'd1 << (nb*8)) - 64'd1);
        build(ext, id, rtr, dlc, data, rsv);
        send_body();
        send_tail(1'b1);
        chk({tag, " R8 frm_vld"}, 64'(frm_vld), 64'd1);
        chk({tag, " R2 id"}, 64'(frm_id), ext ? 64'(id) : 64'({id[28:18], 18'h0}));
        chk({tag, " R2 ext"}, 64'(frm_ext), 64'(ext));
        chk({tag, " R2 rtr"}, 64'(frm_rtr), 64'(rtr));
        chk({tag, " R4 dlc"}, 64'(frm_dlc), 64'(dlc));
        chk({tag, " R4 data"}, frm_data, data & mask);
    endtask

    task automatic t_reset();
        chk("R8 reset frm_vld", 64'(frm_vld), 64'd0);
        chk("R6 reset ack_drive", 64'(ack_drive), 64'd0);
        chk("R11 reset bus_idle", 64'(bus_idle), 64'd1);
    endtask

    task automatic t_idle_recessive();
        for (int i = 0; i < 3; i++) begin
            send_bit(1'b1, 1'b0);
            chk("R1 recessive in idle gives no sof", 64'(sof_det), 64'd0);
        end
        send_bit(1'b0, 1'b1);
        chk("R10 stuff-flagged dominant gives no sof", 64'(sof_det), 64'd0);
        chk("R10 stuff-flagged dominant keeps idle", 64'(bus_idle), 64'd1);
    endtask

    task automatic inter_idle();
        for (int i = 0; i < 3; i++) begin
            chk("R11 not idle before intermission ends", 64'(bus_idle), 64'd0);
            send_bit(1'b1, 1'b0);
        end
        chk("R11 idle after three recessive slots", 64'(bus_idle), 64'd1);
    endtask

    task automatic t_standard();
        rx_frame("std", 1'b0, {11'h000, 18'h0}, 1'b0, 4'd2, 64'h0000_0000_0000_FF00, 1'b0);
        inter_idle();
    endtask

    task automatic t_extended();
        rx_frame("ext R3 rsv recessive", 1'b1, 29'h1ABCDE5F, 1'b0, 4'hC,
                 64'h0123_4567_89AB_CDEF, 1'b1);
        inter_idle();
    endtask

    task automatic t_remote();
        rx_frame("rtr R3", 1'b0, {11'h5A5, 18'h0}, 1'b1, 4'd3, 64'hDEAD_BEEF_1234_5678, 1'b1);
        inter_idle();
    endtask

    task automatic t_crc_error();
        build(1'b0, {11'h2F0, 18'h0}, 1'b0, 4'd1, 64'h3C, 1'b0);
        fb[fl-3] = ~fb[fl-3];
        send_body();
        send_tail(1'b0);
        chk("R5 no frm_vld after CRC mismatch", 64'(frm_vld), 64'd0);
        inter_idle();
    endtask

    task automatic t_form_error();
        build(1'b0, {11'h111, 18'h0}, 1'b0, 4'd1, 64'h81, 1'b0);
        send_body();
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        chk("R7 form_err on dominant EOF bit", 64'(form_err), 64'd1);
        chk("R7 no frm_vld on EOF form error", 64'(frm_vld), 64'd0);
        chk("R7 idle after form error", 64'(bus_idle), 64'd1);
        build(1'b0, {11'h222, 18'h0}, 1'b0, 4'd0, 64'h0, 1'b0);
        send_body();
        send_bit(1'b0, 1'b0);
        chk("R7 form_err on dominant CRC delimiter", 64'(form_err), 64'd1);
        chk("R7 no ack on CRC delimiter form error", 64'(ack_drive), 64'd0);
        chk("R7 idle after CRC delimiter error", 64'(bus_idle), 64'd1);
    endtask

    task automatic t_overload();
        for (int slot = 0; slot < 2; slot++) begin
            rx_frame("pre-overload", 1'b0, {11'h333, 18'h0}, 1'b0, 4'd1, 64'h55, 1'b0);
            if (slot == 1) send_bit(1'b1, 1'b0);
            send_bit(1'b0, 1'b0);
            chk("R9 ovld_det on early intermission dominant", 64'(ovld_det), 64'd1);
            chk("R9 no sof on early intermission dominant", 64'(sof_det), 64'd0);
            for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
            for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
            chk("R9 still in overload before 8th recessive", 64'(bus_idle), 64'd0);
            send_bit(1'b1, 1'b0);
            inter_idle();
        end
    endtask

    task automatic t_sof_slot3();
        rx_frame("pre-slot3", 1'b0, {11'h444, 18'h0}, 1'b0, 4'd1, 64'hA5, 1'b0);
        send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        rx_frame("R9 slot3 sof frame", 1'b1, 29'h0000_1234, 1'b0, 4'd8, 64'hFFFF_0000_FFFF_0000, 1'b0);
        chk("R9 no overload on slot-3 sof", 64'(ovld_det), 64'd0);
        inter_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_recessive();
        t_standard();
        t_extended();
        t_remote();
        t_crc_error();
        t_form_error();
        t_overload();
        t_sof_slot3();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule